// File: doc/BRIEF.md
# Function-Bit Arithmetic-Logic Unit

This block is the 16-bit arithmetic-logic unit of a small RISC core. It takes two operands, the 5-bit opcode and the 2-bit function field from the low end of the instruction word. It returns a result together with carry and zero flags. Operations that are closely related share one opcode, and the function field picks between them inside the unit. Plain add and add-including-carry share one opcode. Subtract and subtract-with-borrow share another. The four bitwise operations share a third.

The datapath is purely combinational. A small flag register holds the carry and zero flags. It loads them only when the update-enable input is high and the opcode is supported. The stored carry feeds back as the carry or borrow input of the carry-using variants. Multiply, divide, floating point, register-file access and immediate generation are not part of this block.

Top module: `fnalu_core`

## Requirements
- R1: Opcode 00000 with function 00 gives result = (op_a + op_b) mod 2^16 and carry_out = bit 16 of the sum; the stored carry has no effect.
- R2: Opcode 00000 with function 01 gives result = (op_a + op_b + stored carry) mod 2^16, with carry_out the bit-16 carry of that sum.
- R3: Opcode 00001 with function 00 gives result = (op_a - op_b) mod 2^16, with carry_out = 1 exactly when op_a < op_b as unsigned values (borrow).
- R4: Opcode 00001 with function 01 gives result = (op_a - op_b - stored carry) mod 2^16, with carry_out = 1 exactly when op_a < op_b + stored carry (unsigned).
- R5: Opcode 00010 selects bitwise logic: function 00 is AND, 01 is OR, 10 is XOR.
- R6: Opcode 00010 with function 11 gives result = bitwise NOT of op_a; op_b has no effect.
- R7: Every logic operation (opcode 00010) drives carry_out to 0.
- R8: zero_out is 1 exactly when the 16-bit result is zero.
- R9: Reset clears carry_q and zero_q to 0. On a rising clock edge with flag_we = 1 they load carry_out and zero_out. With flag_we = 0 they hold.
- R10: Any opcode other than 00000, 00001 or 00010 gives result 0, carry_out 0 and zero_out 1. The stored flags do not change, even when flag_we = 1.
- R11: In the add and subtract groups only function bit 0 matters: function 10 acts as 00 and 11 acts as 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 16 | First source operand |
| op_b | input | 16 | Second source operand |
| opcode | input | 5 | Instruction opcode |
| fn_sel | input | 2 | Function field that selects the variant |
| flag_we | input | 1 | Flag update enable |
| result | output | 16 | Operation result |
| carry_out | output | 1 | Carry of an add or borrow of a subtract, 0 for logic |
| zero_out | output | 1 | Result-is-zero flag |
| carry_q | output | 1 | Stored carry flag |
| zero_q | output | 1 | Stored zero flag |

## Verification
The bench first sets the stored carry to 1 and then issues a plain add. A design that leaks the stored carry into the add would return a sum one too high. Subtract is driven across equal operands, one-smaller and one-larger operands, and with the borrow-in at 0x0000 minus 0x0000. A design with an inverted borrow sense, or one that counts the borrow-in only once, returns the wrong carry or a result off by one.

NOT is issued with several different second operands, and the function-10 and function-11 aliases are compared against their base variants. A design that decodes the full function field would show a difference there. Unsupported opcodes are issued with flag_we high. A design without the update gate would overwrite the stored flags with 0 and 1.

// File: rtl/fnalu_pkg.sv
package fnalu_pkg;

   typedef enum logic [1:0] {
      GRP_ARITH = 2'd0,
      GRP_LOGIC = 2'd1,
      GRP_NONE  = 2'd2
   } grp_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOT = 2'd3
   } lsel_e;

   typedef struct packed {
      grp_e  grp;
      logic  sub;
      logic  use_cf;
      lsel_e lsel;
   } ctl_t;

   localparam logic [4:0] DEF_OPC_ADD   = 5'b00000;
   localparam logic [4:0] DEF_OPC_SUB   = 5'b00001;
   localparam logic [4:0] DEF_OPC_LOGIC = 5'b00010;

endpackage

// File: rtl/fnalu_decode.sv
module fnalu_decode
   import fnalu_pkg::*;
#(
   parameter int         OPC_W     = 5,
   parameter int         FN_W      = 2,
   parameter logic [4:0] OPC_ADD   = DEF_OPC_ADD,
   parameter logic [4:0] OPC_SUB   = DEF_OPC_SUB,
   parameter logic [4:0] OPC_LOGIC = DEF_OPC_LOGIC
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  fn_sel,
   output ctl_t             ctl
);

   generate
      if (OPC_W != 5) begin : g_bad_opc
         $error("fnalu_decode: OPC_W must be 5");
      end
      if (FN_W != 2) begin : g_bad_fn
         $error("fnalu_decode: FN_W must be 2");
      end
   endgenerate

   always_comb begin
      ctl        = '0;
      ctl.grp    = GRP_NONE;
      ctl.lsel   = lsel_e'(fn_sel);
      if (opcode == OPC_ADD) begin
         ctl.grp    = GRP_ARITH;
         ctl.use_cf = fn_sel[0];
      end else if (opcode == OPC_SUB) begin
         ctl.grp    = GRP_ARITH;
         ctl.sub    = 1'b1;
         ctl.use_cf = fn_sel[0];
      end else if (opcode == OPC_LOGIC) begin
         ctl.grp    = GRP_LOGIC;
      end
   end

endmodule

// File: rtl/fnalu_arith.sv
module fnalu_arith #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   input  logic             use_cf,
   input  logic             cflag,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   logic [WIDTH-1:0] b_eff;
   logic             cin_eff;
   logic             c_top;

   generate
      if (WIDTH < 2) begin : g_bad_w
         $error("fnalu_arith: WIDTH must be at least 2");
      end
   endgenerate

   // subtract runs as a + ~b + 1 - borrow_in; the borrow is the inverted top carry
   assign b_eff   = sub ? ~b : b;
   assign cin_eff = sub ? ~(use_cf & cflag) : (use_cf & cflag);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] ch;
         assign ch[0] = cin_eff;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ ch[i];
            assign ch[i+1] = (a[i] & b_eff[i]) | (ch[i] & (a[i] ^ b_eff[i]));
         end
         assign c_top = ch[WIDTH];
      end else begin : g_infer
         assign {c_top, sum} = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
      end
   endgenerate

   assign cout = sub ? ~c_top : c_top;

endmodule

// File: rtl/fnalu_logic.sv
module fnalu_logic
   import fnalu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  lsel_e            lsel,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (lsel)
         LG_AND:  y = a & b;
         LG_OR:   y = a | b;
         LG_XOR:  y = a ^ b;
         default: y = ~a;
      endcase
   end

endmodule

// File: rtl/fnalu_flags.sv
module fnalu_flags #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] res,
   input  logic             cin,
   output logic             zero,
   output logic             carry_q,
   output logic             zero_q
);

   assign zero = (res == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
         zero_q  <= 1'b0;
      end else if (we) begin
         carry_q <= cin;
         zero_q  <= zero;
      end
   end

   // R9: flags hold while the enable is low
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(carry_q) && $stable(zero_q)));

   // R9: flags capture the carry presented on an enabled edge
   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (carry_q == $past(cin)));

endmodule

// File: rtl/fnalu_core.sv
module fnalu_core
   import fnalu_pkg::*;
#(
   parameter int         WIDTH     = 16,
   parameter int         OPC_W     = 5,
   parameter int         FN_W      = 2,
   parameter bit         RIPPLE    = 1'b0,
   parameter logic [4:0] OPC_ADD   = DEF_OPC_ADD,
   parameter logic [4:0] OPC_SUB   = DEF_OPC_SUB,
   parameter logic [4:0] OPC_LOGIC = DEF_OPC_LOGIC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  fn_sel,
   input  logic             flag_we,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             zero_out,
   output logic             carry_q,
   output logic             zero_q
);

   localparam int SUM_W = WIDTH + 1;

   ctl_t             ctl;
   logic [WIDTH-1:0] arith_y;
   logic             arith_c;
   logic [WIDTH-1:0] logic_y;
   logic             op_ok;

   fnalu_decode #(
      .OPC_W(OPC_W), .FN_W(FN_W),
      .OPC_ADD(OPC_ADD), .OPC_SUB(OPC_SUB), .OPC_LOGIC(OPC_LOGIC)
   ) u_dec (
      .opcode(opcode), .fn_sel(fn_sel), .ctl(ctl)
   );

   fnalu_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .a(op_a), .b(op_b), .sub(ctl.sub), .use_cf(ctl.use_cf),
      .cflag(carry_q), .sum(arith_y), .cout(arith_c)
   );

   fnalu_logic #(.WIDTH(WIDTH)) u_logic (
      .a(op_a), .b(op_b), .lsel(ctl.lsel), .y(logic_y)
   );

   always_comb begin
      op_ok = 1'b1;
      unique case (ctl.grp)
         GRP_ARITH: begin
            result    = arith_y;
            carry_out = arith_c;
         end
         GRP_LOGIC: begin
            result    = logic_y;
            carry_out = 1'b0;
         end
         default: begin
            result    = '0;
            carry_out = 1'b0;
            op_ok     = 1'b0;
         end
      endcase
   end

   fnalu_flags #(.WIDTH(WIDTH)) u_flags (
      .clk(clk), .rst_n(rst_n), .we(flag_we & op_ok),
      .res(result), .cin(carry_out), .zero(zero_out),
      .carry_q(carry_q), .zero_q(zero_q)
   );

   // R1: plain add matches a wide sum of the two operands
   p_plain_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_ADD && !fn_sel[0]) |->
         ({carry_out, result} == (SUM_W'(op_a) + SUM_W'(op_b))));

   // R7: logic group never reports a carry
   p_logic_nocarry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_LOGIC) |-> !carry_out);

   // R8: nonzero result never flags zero
   p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (result != '0) |-> !zero_out);

   // R10: unsupported opcodes leave the stored flags alone
   p_bad_op_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode != OPC_ADD && opcode != OPC_SUB && opcode != OPC_LOGIC) |=>
         ($stable(carry_q) && $stable(zero_q)));

endmodule

// File: tb/tb_fnalu_core.sv
module tb_fnalu_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic [4:0]  opcode = '0;
   logic [1:0]  fn_sel = '0;
   logic        flag_we = 1'b0;
   logic [15:0] result;
   logic        carry_out, zero_out, carry_q, zero_q;

   int n_chk = 0;
   int n_bad = 0;
   logic exp_cf = 1'b0;
   logic exp_zf = 1'b0;

   always #5 clk = ~clk;

   fnalu_core dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
      .fn_sel(fn_sel), .flag_we(flag_we), .result(result), .carry_out(carry_out),
      .zero_out(zero_out), .carry_q(carry_q), .zero_q(zero_q)
   );

   function automatic logic [16:0] model(input logic [4:0] opc, input logic [1:0] fn,
                                         input logic [15:0] a, input logic [15:0] b,
                                         input logic cf);
      logic cin;
      logic [15:0] r;
      cin = fn[0] & cf;
      case (opc)
         5'b00000: return {1'b0, a} + {1'b0, b} + {16'd0, cin};
         5'b00001: begin
            r = a - b - {15'd0, cin};
            return {({1'b0, a} < ({1'b0, b} + {16'd0, cin})), r};
         end
         5'b00010: case (fn)
            2'b00:   return {1'b0, a & b};
            2'b01:   return {1'b0, a | b};
            2'b10:   return {1'b0, a ^ b};
            default: return {1'b0, ~a};
         endcase
         default: return 17'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_op(input string tag, input logic [4:0] opc, input logic [1:0] fn,
                           input logic [15:0] a, input logic [15:0] b);
      logic [16:0] e;
      opcode = opc; fn_sel = fn; op_a = a; op_b = b; flag_we = 1'b0;
      #1;
      e = model(opc, fn, a, b, exp_cf);
      chk({tag, " result"}, {16'd0, result}, {16'd0, e[15:0]});
      chk({tag, " carry"}, {31'd0, carry_out}, {31'd0, e[16]});
      chk({tag, " zero (R8)"}, {31'd0, zero_out}, {31'd0, e[15:0] == 16'd0});
   endtask

   // applies an operation with the update enable high and clocks it once
   task automatic load_op(input logic [4:0] opc, input logic [1:0] fn,
                          input logic [15:0] a, input logic [15:0] b);
      logic [16:0] e;
      logic ok;
      ok = (opc == 5'b00000 || opc == 5'b00001 || opc == 5'b00010);
      e = model(opc, fn, a, b, exp_cf);
      opcode = opc; fn_sel = fn; op_a = a; op_b = b; flag_we = 1'b1;
      @(posedge clk); #1;
      flag_we = 1'b0;
      if (ok) begin
         exp_cf = e[16];
         exp_zf = (e[15:0] == 16'd0);
      end
   endtask

   task automatic set_cf(input logic v);
      if (v) load_op(5'b00000, 2'b00, 16'hFFFF, 16'h0001);
      else   load_op(5'b00000, 2'b00, 16'h0001, 16'h0001);
   endtask

   task automatic t_reset;
      chk("R9 reset carry_q", {31'd0, carry_q}, 32'd0);
      chk("R9 reset zero_q", {31'd0, zero_q}, 32'd0);
   endtask

   task automatic t_add;
      set_cf(1'b1);
      check_op("R1 add small", 5'b00000, 2'b00, 16'h1234, 16'h0101);
      check_op("R1 add wrap", 5'b00000, 2'b00, 16'hFFFF, 16'h0001);
      check_op("R1 add ignores cf", 5'b00000, 2'b00, 16'h0000, 16'h0000);
      check_op("R1 add carry", 5'b00000, 2'b00, 16'h8000, 16'h8001);
   endtask

   task automatic t_adc;
      set_cf(1'b1);
      check_op("R2 adc cf1", 5'b00000, 2'b01, 16'h7FFF, 16'h0000);
      check_op("R2 adc wrap", 5'b00000, 2'b01, 16'hFFFF, 16'h0000);
      set_cf(1'b0);
      check_op("R2 adc cf0", 5'b00000, 2'b01, 16'h00FF, 16'h0001);
   endtask

   task automatic t_sub;
      set_cf(1'b1);
      check_op("R3 sub pos", 5'b00001, 2'b00, 16'h0005, 16'h0003);
      check_op("R3 sub neg", 5'b00001, 2'b00, 16'h0003, 16'h0005);
      check_op("R3 sub eq", 5'b00001, 2'b00, 16'hABCD, 16'hABCD);
   endtask

   task automatic t_sbb;
      set_cf(1'b1);
      check_op("R4 sbb eq borrow", 5'b00001, 2'b01, 16'h0005, 16'h0005);
      check_op("R4 sbb zero", 5'b00001, 2'b01, 16'h0000, 16'h0000);
      check_op("R4 sbb plain", 5'b00001, 2'b01, 16'h0010, 16'h0001);
      set_cf(1'b0);
      check_op("R4 sbb cf0", 5'b00001, 2'b01, 16'h0005, 16'h0005);
   endtask

   task automatic t_logic;
      set_cf(1'b1);
      check_op("R5 and", 5'b00010, 2'b00, 16'hF0F0, 16'h3C3C);
      check_op("R5 or", 5'b00010, 2'b01, 16'hF0F0, 16'h0F0F);
      check_op("R5 xor", 5'b00010, 2'b10, 16'hAAAA, 16'hAAAA);
      check_op("R7 and carry", 5'b00010, 2'b00, 16'hFFFF, 16'hFFFF);
   endtask

   task automatic t_not;
      check_op("R6 not b0", 5'b00010, 2'b11, 16'h1234, 16'h0000);
      check_op("R6 not b1", 5'b00010, 2'b11, 16'h1234, 16'hFFFF);
      check_op("R6 not all1", 5'b00010, 2'b11, 16'hFFFF, 16'h5A5A);
   endtask

   task automatic t_alias;
      logic [15:0] r0;
      logic c0;
      set_cf(1'b1);
      for (int k = 0; k < 2; k++) begin
         opcode = k[0] ? 5'b00001 : 5'b00000;
         op_a = 16'h4000; op_b = 16'h4001;
         fn_sel = 2'b00; #1; r0 = result; c0 = carry_out;
         fn_sel = 2'b10; #1;
         chk("R11 alias 10 result", {16'd0, result}, {16'd0, r0});
         chk("R11 alias 10 carry", {31'd0, carry_out}, {31'd0, c0});
         fn_sel = 2'b01; #1; r0 = result; c0 = carry_out;
         fn_sel = 2'b11; #1;
         chk("R11 alias 11 result", {16'd0, result}, {16'd0, r0});
         chk("R11 alias 11 carry", {31'd0, carry_out}, {31'd0, c0});
      end
   endtask

   task automatic t_flags;
      load_op(5'b00001, 2'b00, 16'h0001, 16'h0002);
      chk("R9 load carry", {31'd0, carry_q}, {31'd0, exp_cf});
      chk("R9 load zero", {31'd0, zero_q}, {31'd0, exp_zf});
      check_op("R9 setup", 5'b00001, 2'b00, 16'h0002, 16'h0002);
      @(posedge clk); #1;
      chk("R9 hold carry", {31'd0, carry_q}, 32'd1);
      chk("R9 hold zero", {31'd0, zero_q}, 32'd0);
      load_op(5'b00000, 2'b00, 16'h0000, 16'h0000);
      chk("R9 load zero set", {31'd0, zero_q}, 32'd1);
      chk("R9 load carry clr", {31'd0, carry_q}, 32'd0);
   endtask

   task automatic t_invalid;
      set_cf(1'b1);
      load_op(5'b00001, 2'b00, 16'h0009, 16'h0001);
      check_op("R10 bad op 1f", 5'b11111, 2'b01, 16'hFFFF, 16'h0001);
      check_op("R10 bad op 03", 5'b00011, 2'b00, 16'h1234, 16'h1234);
      load_op(5'b11111, 2'b00, 16'hFFFF, 16'hFFFF);
      chk("R10 carry_q kept", {31'd0, carry_q}, 32'd0);
      chk("R10 zero_q kept", {31'd0, zero_q}, 32'd0);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_add;
      t_adc;
      t_sub;
      t_sbb;
      t_logic;
      t_not;
      t_alias;
      t_flags;
      t_invalid;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule